// File: doc/BRIEF.md
# Memory-Management Abort Status Register

This block holds the 16-bit status word that a minicomputer-style memory-management unit uses to describe the first address-translation abort it sees. The translation stage reports a fault with its class, the access-control code of the page, the processor run mode and the active page field number. The register records the fault in fixed bit fields. In the next cycle it raises a trap-vector request and a strobe that marks the faulting page's descriptor as accessed.

The CPU signals each trap entry and says whether the entry is a real trap or an interrupt. The register keeps that distinction in one bit. Software can write the whole word or set or clear a single bit by index. Two bits are shielded from the single-bit clear. Once any abort flag is set, the register ignores later faults until software clears the flags, so the first fault's information is kept.

Top module: `mmu_abort_status`

## Requirements
- R1: A synchronous active-high `rst` clears `status` to zero and drops `vec_req` and `pdr_mark` at the next rising clock edge.
- R2: A recorded fault first clears bits 15, 14 and 13 and then sets exactly one of them. Bits 12, 11:7, 4 and 0 keep their values.
- R3: Fault class is coded on `flt_kind`: 0 = write to a page that does not allow writes, 1 = read-side access fault. Class 0 sets bit 13. Class 1 sets bit 15 when `flt_acc` is 0 or 4, and bit 13 for any other `flt_acc`.
- R4: Class 2 (page length) sets bit 14. Classes 0, 1 and 2 request vector 0250 octal on `vec_num`.
- R5: Class 3 (physical offset at or beyond installed memory) sets bit 15 and requests vector 04 octal.
- R6: A recorded fault writes `flt_mode` into bits 6:5 and `flt_page` into bits 3:1.
- R7: While any of bits 15:13 is set, a fault is not recorded. `status` fields from the fault do not change, and `vec_req` and `pdr_mark` stay low.
- R8: One cycle after a recorded fault, `pdr_mark` pulses high for one cycle with `pdr_page` and `pdr_mode` equal to the faulting page and mode. `vec_req` pulses high in the same cycle.
- R9: On `trap_entry`, bit 12 takes the value of `trap_is_trap`: 1 for a trap, 0 for an interrupt or scheduled MMU-fault entry.
- R10: `bit_set` sets bit `bit_idx` for any index 0 to 15. `bit_clr` (used only when `bit_set` is low) clears bit `bit_idx`, but index 10, index 11 and any index of 16 or more leave `status` unchanged.
- R11: `sw_wr` loads `sw_wdata` into all 16 bits and takes priority over a fault, a trap entry and a bit operation in the same cycle. A fault in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault report strobe from translation |
| flt_kind | input | 2 | Fault class (0 write-protect, 1 read-side, 2 length, 3 beyond memory) |
| flt_acc | input | 3 | Access-control code of the faulting page |
| flt_mode | input | 2 | Run mode of the faulting access |
| flt_page | input | 3 | Active page field number of the faulting access |
| trap_entry | input | 1 | CPU trap-entry strobe |
| trap_is_trap | input | 1 | 1 = trap, 0 = interrupt or scheduled fault entry |
| sw_wr | input | 1 | Full-word software write |
| sw_wdata | input | 16 | Software write data |
| bit_set | input | 1 | Single-bit set request |
| bit_clr | input | 1 | Single-bit clear request |
| bit_idx | input | IDX_W | Bit index for set or clear |
| status | output | 16 | Abort status word |
| vec_req | output | 1 | Trap-vector request pulse |
| vec_num | output | VEC_W | Requested vector |
| pdr_mark | output | 1 | Strobe to mark page descriptor as accessed |
| pdr_page | output | 3 | Page field number for the mark |
| pdr_mode | output | 2 | Run mode for the mark |

## Verification
The bench uses the default parameters: `VEC_W` = 8, which holds 0250 octal, and `IDX_W` = 5. The five-bit index lets the bench drive indices 16 to 31, which reaches the out-of-range case of the single-bit clear next to the shielded indices 10 and 11. The random stimulus keeps full writes rare, so the register stays locked for long stretches and the lock is exercised. Same-cycle collisions of write, fault, trap entry and bit operations also occur.

// File: rtl/mmu_abort_pkg.sv
package mmu_abort_pkg;
  localparam int REG_W    = 16;
  localparam int MODE_W   = 2;
  localparam int PAGE_W   = 3;
  localparam int ACC_W    = 3;
  // field positions decoded by the trap handler
  localparam int B_NONRES = 15;
  localparam int B_LENGTH = 14;
  localparam int B_RDONLY = 13;
  localparam int B_TRAP   = 12;
  localparam int B_SHLD_A = 11;
  localparam int B_SHLD_B = 10;
  localparam int MODE_LSB = 5;
  localparam int PAGE_LSB = 1;

  typedef enum logic [1:0] {
    FK_WPROT  = 2'd0,
    FK_READ   = 2'd1,
    FK_LENGTH = 2'd2,
    FK_NOMEM  = 2'd3
  } fault_kind_e;
endpackage

// File: rtl/mmu_abort_classify.sv
module mmu_abort_classify
  import mmu_abort_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_LEN = 8'o250,
  parameter logic [VEC_W-1:0] VEC_BUS = 8'o4
) (
  input  logic [1:0]       kind,
  input  logic [ACC_W-1:0] acc,
  output logic [2:0]       flags,   // {nonres, length, rdonly}
  output logic [VEC_W-1:0] vec
);
  logic acc_absent;
  assign acc_absent = (acc == ACC_W'(0)) || (acc == ACC_W'(4));

  always_comb begin
    flags = 3'b000;
    vec   = VEC_LEN;
    unique case (fault_kind_e'(kind))
      FK_WPROT:  flags = 3'b001;
      FK_READ:   flags = acc_absent ? 3'b100 : 3'b001;
      FK_LENGTH: flags = 3'b010;
      FK_NOMEM: begin
        flags = 3'b100;
        vec   = VEC_BUS;
      end
      default:   flags = 3'b000;
    endcase
  end
endmodule

// File: rtl/mmu_abort_bitop.sv
module mmu_abort_bitop
  import mmu_abort_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [REG_W-1:0] cur,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] idx,
  output logic [REG_W-1:0] nxt
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    localparam bit SHIELD = (i == B_SHLD_A) || (i == B_SHLD_B);
    logic hit;
    assign hit = (idx == IDX_W'(i));
    if (SHIELD) begin : g_shield
      assign nxt[i] = (set_en && hit) ? 1'b1 : cur[i];
    end else begin : g_open
      assign nxt[i] = (set_en && hit) ? 1'b1 :
                      (!set_en && clr_en && hit) ? 1'b0 : cur[i];
    end
  end
endmodule

// File: rtl/mmu_abort_status.sv
module mmu_abort_status
  import mmu_abort_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_LEN = 8'o250,
  parameter logic [VEC_W-1:0] VEC_BUS = 8'o4,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_valid,
  input  logic [1:0]        flt_kind,
  input  logic [2:0]        flt_acc,
  input  logic [1:0]        flt_mode,
  input  logic [2:0]        flt_page,
  input  logic              trap_entry,
  input  logic              trap_is_trap,
  input  logic              sw_wr,
  input  logic [15:0]       sw_wdata,
  input  logic              bit_set,
  input  logic              bit_clr,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic [15:0]       status,
  output logic              vec_req,
  output logic [VEC_W-1:0]  vec_num,
  output logic              pdr_mark,
  output logic [2:0]        pdr_page,
  output logic [1:0]        pdr_mode
);
  logic [2:0]       cls_flags;
  logic [VEC_W-1:0] cls_vec;
  logic [REG_W-1:0] after_bit;
  logic [REG_W-1:0] st_nxt;
  logic             locked;
  logic             capture;

  mmu_abort_classify #(
    .VEC_W(VEC_W), .VEC_LEN(VEC_LEN), .VEC_BUS(VEC_BUS)
  ) u_cls (
    .kind (flt_kind),
    .acc  (flt_acc),
    .flags(cls_flags),
    .vec  (cls_vec)
  );

  mmu_abort_bitop #(.IDX_W(IDX_W)) u_bit (
    .cur   (status),
    .set_en(bit_set),
    .clr_en(bit_clr),
    .idx   (bit_idx),
    .nxt   (after_bit)
  );

  assign locked  = |status[B_NONRES:B_RDONLY];
  assign capture = flt_valid && !locked && !sw_wr;

  always_comb begin
    st_nxt = after_bit;
    if (capture) begin
      st_nxt[B_NONRES:B_RDONLY]          = cls_flags;
      st_nxt[MODE_LSB+MODE_W-1:MODE_LSB] = flt_mode;
      st_nxt[PAGE_LSB+PAGE_W-1:PAGE_LSB] = flt_page;
    end
    if (trap_entry) st_nxt[B_TRAP] = trap_is_trap;
    if (sw_wr)      st_nxt = sw_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= '0;
      vec_req  <= 1'b0;
      vec_num  <= '0;
      pdr_mark <= 1'b0;
      pdr_page <= '0;
      pdr_mode <= '0;
    end else begin
      status   <= st_nxt;
      vec_req  <= capture;
      pdr_mark <= capture;
      if (capture) begin
        vec_num  <= cls_vec;
        pdr_page <= flt_page;
        pdr_mode <= flt_mode;
      end
    end
  end
endmodule

// File: rtl/mmu_abort_status_sva.sv
module mmu_abort_status_sva #(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_LEN = 8'o250,
  parameter logic [VEC_W-1:0] VEC_BUS = 8'o4,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             flt_valid,
  input logic             trap_entry,
  input logic             trap_is_trap,
  input logic             sw_wr,
  input logic             bit_set,
  input logic             bit_clr,
  input logic [15:0]      status,
  input logic             vec_req,
  input logic [VEC_W-1:0] vec_num,
  input logic             pdr_mark,
  input logic [2:0]       pdr_page,
  input logic [1:0]       pdr_mode
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (status == 16'h0) && !vec_req && !pdr_mark);

  a_r2_single_flag: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> $onehot(status[15:13]));

  a_r4_length_vector: assert property (@(posedge clk) disable iff (rst)
    (vec_req && status[14]) |-> (vec_num == VEC_LEN));

  a_r5_bus_vector_nonres: assert property (@(posedge clk) disable iff (rst)
    (vec_req && vec_num == VEC_BUS) |-> status[15]);

  a_r7_locked_no_req: assert property (@(posedge clk) disable iff (rst)
    ((|status[15:13]) && flt_valid) |=> !vec_req && !pdr_mark);

  a_r8_mark_fields: assert property (@(posedge clk) disable iff (rst)
    pdr_mark |-> (pdr_page == status[3:1]) && (pdr_mode == status[6:5]));

  a_r9_trap_bit: assert property (@(posedge clk) disable iff (rst)
    (trap_entry && !sw_wr) |=> (status[12] == $past(trap_is_trap)));

  a_r10_shielded_bits: assert property (@(posedge clk) disable iff (rst)
    (bit_clr && !bit_set && !sw_wr) |=> (status[11:10] == $past(status[11:10])));
endmodule

bind mmu_abort_status mmu_abort_status_sva #(
  .VEC_W(VEC_W), .VEC_LEN(VEC_LEN), .VEC_BUS(VEC_BUS), .IDX_W(IDX_W)
) u_sva (
  .clk(clk), .rst(rst), .flt_valid(flt_valid), .trap_entry(trap_entry),
  .trap_is_trap(trap_is_trap), .sw_wr(sw_wr), .bit_set(bit_set),
  .bit_clr(bit_clr), .status(status), .vec_req(vec_req), .vec_num(vec_num),
  .pdr_mark(pdr_mark), .pdr_page(pdr_page), .pdr_mode(pdr_mode)
);

// File: tb/mmu_abort_status_test.sv
module mmu_abort_status_test;
  localparam int CLK_P = 10;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst, flt_valid, trap_entry, trap_is_trap, sw_wr, bit_set, bit_clr;
  logic [1:0] flt_kind, flt_mode;
  logic [2:0] flt_acc, flt_page;
  logic [15:0] sw_wdata;
  logic [IDX_W-1:0] bit_idx;
  logic [15:0] status;
  logic vec_req, pdr_mark;
  logic [7:0] vec_num;
  logic [2:0] pdr_page;
  logic [1:0] pdr_mode;

  mmu_abort_status uut (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_kind(flt_kind),
    .flt_acc(flt_acc), .flt_mode(flt_mode), .flt_page(flt_page),
    .trap_entry(trap_entry), .trap_is_trap(trap_is_trap), .sw_wr(sw_wr),
    .sw_wdata(sw_wdata), .bit_set(bit_set), .bit_clr(bit_clr),
    .bit_idx(bit_idx), .status(status), .vec_req(vec_req),
    .vec_num(vec_num), .pdr_mark(pdr_mark), .pdr_page(pdr_page),
    .pdr_mode(pdr_mode)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] m_st;

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%06o exp=%06o", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_flags(logic [1:0] k, logic [2:0] a);
    case (k)
      2'd0: return 3'b001;
      2'd1: return (a == 3'd0 || a == 3'd4) ? 3'b100 : 3'b001;
      2'd2: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic logic [7:0] exp_vec(logic [1:0] k);
    return (k == 2'd3) ? 8'o4 : 8'o250;
  endfunction

  task automatic idle();
    flt_valid = 0; trap_entry = 0; sw_wr = 0; bit_set = 0; bit_clr = 0;
  endtask

  task automatic step(string tag);
    logic [15:0] e;
    bit cap;
    logic [1:0] k;
    logic [1:0] md;
    logic [2:0] pg;
    e = m_st;
    if (bit_set && bit_idx < 16) e[bit_idx[3:0]] = 1'b1;
    else if (!bit_set && bit_clr && bit_idx < 16 && bit_idx != 10 && bit_idx != 11)
      e[bit_idx[3:0]] = 1'b0;
    cap = flt_valid && (m_st[15:13] == 3'b000) && !sw_wr;
    k = flt_kind; md = flt_mode; pg = flt_page;
    if (cap) begin
      e[15:13] = exp_flags(flt_kind, flt_acc);
      e[6:5] = flt_mode;
      e[3:1] = flt_page;
    end
    if (trap_entry) e[12] = trap_is_trap;
    if (sw_wr) e = sw_wdata;
    @(posedge clk);
    @(negedge clk);
    chk(status == e, {tag, " status"}, status, e);
    chk(vec_req == cap, {tag, " R8 vec_req"}, 16'(vec_req), 16'(cap));
    chk(pdr_mark == cap, {tag, " R8 pdr_mark"}, 16'(pdr_mark), 16'(cap));
    if (cap) begin
      chk(vec_num == exp_vec(k), {tag, " R4 vec_num"}, 16'(vec_num), 16'(exp_vec(k)));
      chk(pdr_page == pg && pdr_mode == md, {tag, " R8 pdr fields"},
          {11'd0, pdr_mode, pdr_page}, {11'd0, md, pg});
    end
    m_st = e;
  endtask

  task automatic fault(logic [1:0] k, logic [2:0] a, logic [1:0] md, logic [2:0] pg);
    flt_valid = 1; flt_kind = k; flt_acc = a; flt_mode = md; flt_page = pg;
  endtask

  task automatic wr(logic [15:0] d);
    sw_wr = 1; sw_wdata = d;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd24680));
    idle();
    flt_kind = 0; flt_acc = 0; flt_mode = 0; flt_page = 0; trap_is_trap = 0;
    sw_wdata = 0; bit_idx = 0;
    rst = 1;
    fault(2'd1, 3'd0, 2'd3, 3'd7);
    @(negedge clk); @(negedge clk);
    chk(status == 16'h0, "R1 reset status", status, 16'h0);
    chk(!vec_req && !pdr_mark, "R1 reset pulses", {14'd0, vec_req, pdr_mark}, 16'h0);
    rst = 0; idle(); m_st = 16'h0;

    // R11 full write, preset unrelated bits
    wr(16'o006621); step("R11 write");
    idle();
    // R3 read-side code 4 -> nonresident; R2 keeps bits; R6 fields
    fault(2'd1, 3'd4, 2'd3, 3'd5); step("R3 R6 R2 read acc4");
    idle();
    chk(status[15:13] == 3'b100, "R3 nonres flag", {13'd0, status[15:13]}, 16'o4);
    chk(status[6:5] == 2'd3 && status[3:1] == 3'd5, "R6 fields",
        {9'd0, status[6:5], 1'b0, status[3:1], 1'b0}, 16'o0152);
    // R7 locked
    fault(2'd2, 3'd1, 2'd0, 3'd2); step("R7 locked");
    idle();
    // R11 write beats fault same cycle
    wr(16'h0000); fault(2'd2, 3'd1, 2'd1, 3'd2); step("R11 priority");
    idle();
    chk(status == 16'h0, "R11 fault dropped", status, 16'h0);
    // R4 length
    fault(2'd2, 3'd6, 2'd1, 3'd6); step("R4 length");
    idle();
    wr(16'h0000); step("R11 unlock");
    idle();
    // R5 beyond memory
    fault(2'd3, 3'd6, 2'd0, 3'd1); step("R5 nomem");
    idle();
    chk(status[15] && !status[14] && !status[13], "R5 flag",
        {13'd0, status[15:13]}, 16'o4);
    wr(16'o170000); step("R11 all flags");
    idle();
    bit_clr = 1; bit_idx = 15; step("R10 clear 15");
    bit_idx = 14; step("R10 clear 14");
    bit_idx = 13; step("R10 clear 13");
    idle();
    // R3 write-protect and read with other code
    fault(2'd0, 3'd4, 2'd2, 3'd3); step("R3 wprot");
    idle();
    chk(status[15:13] == 3'b001, "R3 rdonly flag", {13'd0, status[15:13]}, 16'o1);
    wr(16'h0000); step("R11 unlock");
    idle();
    fault(2'd1, 3'd2, 2'd0, 3'd0); step("R3 read acc2");
    idle();
    // R9 trap entry
    trap_entry = 1; trap_is_trap = 1; step("R9 trap");
    chk(status[12] == 1'b1, "R9 bit12 set", 16'(status[12]), 16'd1);
    trap_is_trap = 0; step("R9 interrupt");
    chk(status[12] == 1'b0, "R9 bit12 clear", 16'(status[12]), 16'd0);
    idle();
    // R10 shielded and out of range
    wr(16'o006000); step("R11 preset");
    idle();
    bit_clr = 1; bit_idx = 10; step("R10 clr idx10");
    bit_idx = 11; step("R10 clr idx11");
    bit_idx = 26; step("R10 clr idx26");
    chk(status == 16'o006000, "R10 unchanged", status, 16'o006000);
    idle();
    bit_set = 1; bit_idx = 12; step("R10 set 12");
    bit_idx = 20; step("R10 set idx20");
    idle();
    bit_clr = 1; bit_idx = 12; step("R10 clr 12");
    idle();

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      idle();
      sw_wr = ($urandom % 16) == 0;
      sw_wdata = 16'($urandom);
      if (($urandom % 2) == 0)
        fault(2'($urandom), 3'($urandom), 2'($urandom), 3'($urandom));
      trap_entry = ($urandom % 4) == 0;
      trap_is_trap = 1'($urandom);
      bit_set = ($urandom % 8) == 0;
      bit_clr = ($urandom % 5) == 0;
      bit_idx = IDX_W'($urandom);
      step("R2 R6 R7 R9 R10 random");
    end
    idle();
    rst = 1; @(negedge clk); rst = 0;
    chk(status == 16'h0, "R1 final reset", status, 16'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1'b1;
    $finish;
  end
endmodule